// File: doc/BRIEF.md
# Line-Scan Camera ADC Sequencer

This block owns one shared analog-to-digital converter and walks it through a fixed list of conversions each time a frame-start strobe arrives. Two potentiometers and a battery-sense input are converted first, and their latest results are held on output registers. The block then drives the start and clock pins of two linear image sensors and collects a full line from each of them. The two sensors are interleaved pixel by pixel, so both lines are sampled at the same moments.

The converter is reached through a simple handshake. A one-cycle start pulse carries a channel number and a mux-side flag. A one-cycle done pulse carries a 12-bit result, with full scale at code 4095. Pixels go into a ping-pong frame memory. One bank is written during a frame while the other bank stays readable through a separate read port. When a frame completes, the banks change roles and an 8-bit frame counter advances. Software, or a downstream engine, polls that counter and reads the finished line.

Top module: `lsc_adc_sequencer`

## Requirements
- R1: After reset the sensor start pin, the sensor clock, the converter start and the frame counter are all 0, and the readable bank is bank 1.
- R2: A frame strobe seen while idle raises the sensor start pin on the next clock edge. On that same edge the block issues a converter start on channel 13 with the mux-side flag at 0 (side A).
- R3: A frame requests conversions in this order: channel 13 (side A), channel 12 (side A), channel 4 (side B), then channels 6 and 7 alternating (side B). Each start follows the previous done, never overlaps it, and is one cycle long. The first three results appear on the pot0, pot1 and battery outputs.
- R4: The battery result raises the sensor clock. After exactly HOLD_CYC cycles the sensor start pin falls, and on that same edge the first pixel conversion (channel 6) starts.
- R5: After each camera-1 pixel result the sensor clock goes low for exactly HOLD_CYC cycles and then returns high. No conversion is started while the clock is low during the pixel phase. Each camera-0 conversion starts with the clock high.
- R6: A frame holds PIXELS (128) pixels per camera, giving 129 sensor clock rising edges. After the last pulse the clock stays high for HOLD_CYC cycles and then falls. On that falling edge the frame counter increments by one and the readable bank flips.
- R7: Pixel k of camera c (c = 0 for channel 6, c = 1 for channel 7) is stored at address k of camera c in the working bank. After the swap it can be read with rd_cam_i = c and rd_addr_i = k, and the data appears one cycle after the address.
- R8: The contents of the readable bank never change while it is the readable bank, including while a new frame is being captured.
- R9: A converter done pulse that arrives while idle is discarded. No start is issued, and the held results and the frame counter do not change.
- R10: A frame strobe that arrives while a sequence is running is ignored. The running frame still issues exactly 259 conversions, and none follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start_i | input | 1 | Frame-start strobe |
| adc_start_o | output | 1 | One-cycle conversion request |
| adc_chan_o | output | 5 | Channel number of the request |
| adc_side_b_o | output | 1 | Mux side flag, 1 = side B |
| adc_done_i | input | 1 | One-cycle conversion-complete pulse |
| adc_data_i | input | 12 | Conversion result, valid with done |
| sensor_si_o | output | 1 | Sensor line-start pin |
| sensor_clk_o | output | 1 | Sensor pixel clock pin |
| pot0_o | output | 12 | Latest potentiometer 0 result |
| pot1_o | output | 12 | Latest potentiometer 1 result |
| batt_o | output | 12 | Latest battery-sense result |
| ready_cnt_o | output | 8 | Completed-frame counter |
| rd_bank_o | output | 1 | Bank currently readable |
| rd_cam_i | input | 1 | Camera select for the read port |
| rd_addr_i | input | 7 | Pixel address for the read port |
| rd_data_o | output | 12 | Read data, one cycle after address |

## Verification
The embedded properties check the local ordering on every cycle. The sensor start pin rises only out of idle and always together with a pot-0 request, and its fall coincides with the first pixel request while the clock is high. Start pulses are single cycles, and the mux side matches the channel. No conversion is requested during a low clock pulse, and no write lands in the cycle the banks swap. Whole-frame properties can only be shown by the bench's scenarios: the exact hold widths, the 259-request order, the 129 clock edges, the stored pixel values, the stability of the readable bank during a capture, and the discarding of stray strobes and done pulses.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

  localparam int CH_W = 5;

  localparam logic [CH_W-1:0] CH_POT0 = 5'd13;
  localparam logic [CH_W-1:0] CH_POT1 = 5'd12;
  localparam logic [CH_W-1:0] CH_BATT = 5'd4;
  localparam logic [CH_W-1:0] CH_CAM0 = 5'd6;
  localparam logic [CH_W-1:0] CH_CAM1 = 5'd7;

  localparam int NUM_CAMS = 2;

  typedef enum logic [2:0] {
    S_IDLE,
    S_POT0,
    S_POT1,
    S_BATT,
    S_SETUP,
    S_LINE,
    S_PULSE,
    S_TAIL
  } seq_state_e;

endpackage

// File: rtl/lsc_hold_timer.sv
module lsc_hold_timer #(
  parameter int HOLD_CYC = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic expire_o
);

  localparam int TW = $clog2(HOLD_CYC + 1);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = TW'(HOLD_CYC);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // Last cycle of the hold window; the owner acts on the following edge.
  assign expire_o = (cnt_q == TW'(1));

endmodule

// File: rtl/lsc_frame_buffer.sv
module lsc_frame_buffer
  import lsc_pkg::*;
#(
  parameter int PIXELS = 128,
  parameter int DATA_W = 12,
  localparam int ADDR_W = $clog2(PIXELS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic              wr_cam_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              swap_i,
  input  logic              rd_cam_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_bank_o
);

  localparam int DEPTH = 2 * PIXELS;

  logic              rd_bank_q, rd_bank_d;
  logic [DATA_W-1:0] rd_data_q;
  logic [DATA_W-1:0] rd_word [NUM_CAMS];

  // Writes always target the bank that is not readable.
  for (genvar g = 0; g < NUM_CAMS; g++) begin : g_cam
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en_i && (wr_cam_i == 1'(g))) begin
        mem[{~rd_bank_q, wr_addr_i}] <= wr_data_i;
      end
    end

    assign rd_word[g] = mem[{rd_bank_q, rd_addr_i}];
  end

  always_comb begin
    rd_bank_d = rd_bank_q;
    if (swap_i) begin
      rd_bank_d = ~rd_bank_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_bank_q <= 1'b1;
      rd_data_q <= '0;
    end else begin
      rd_bank_q <= rd_bank_d;
      rd_data_q <= rd_word[rd_cam_i];
    end
  end

  assign rd_data_o = rd_data_q;
  assign rd_bank_o = rd_bank_q;

  // R8: a swap never coincides with a pixel write
  a_r8_no_write_on_swap: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |-> !swap_i);

endmodule

// File: rtl/lsc_seq_fsm.sv
module lsc_seq_fsm
  import lsc_pkg::*;
#(
  parameter int PIXELS = 128,
  parameter int DATA_W = 12,
  parameter int CNT_W  = 8,
  localparam int ADDR_W = $clog2(PIXELS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start_i,
  input  logic              adc_done_i,
  input  logic [DATA_W-1:0] adc_data_i,
  input  logic              tmr_expire_i,
  output logic              tmr_load_o,
  output logic              adc_start_o,
  output logic [CH_W-1:0]   adc_chan_o,
  output logic              adc_side_b_o,
  output logic              sensor_si_o,
  output logic              sensor_clk_o,
  output logic [DATA_W-1:0] pot0_o,
  output logic [DATA_W-1:0] pot1_o,
  output logic [DATA_W-1:0] batt_o,
  output logic [CNT_W-1:0]  ready_cnt_o,
  output logic              wr_en_o,
  output logic              wr_cam_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              swap_o
);

  localparam logic [ADDR_W:0] PIX_END = (ADDR_W+1)'(PIXELS);

  seq_state_e        state_q, state_d;
  logic              si_q, si_d;
  logic              sclk_q, sclk_d;
  logic              start_q, start_d;
  logic [CH_W-1:0]   chan_q, chan_d;
  logic              sideb_q, sideb_d;
  logic              cam_q, cam_d;
  logic [ADDR_W:0]   pix_q, pix_d;
  logic [DATA_W-1:0] pot0_q, pot0_d;
  logic [DATA_W-1:0] pot1_q, pot1_d;
  logic [DATA_W-1:0] batt_q, batt_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    state_d    = state_q;
    si_d       = si_q;
    sclk_d     = sclk_q;
    start_d    = 1'b0;
    chan_d     = chan_q;
    sideb_d    = sideb_q;
    cam_d      = cam_q;
    pix_d      = pix_q;
    pot0_d     = pot0_q;
    pot1_d     = pot1_q;
    batt_d     = batt_q;
    cnt_d      = cnt_q;
    tmr_load_o = 1'b0;
    wr_en_o    = 1'b0;
    swap_o     = 1'b0;

    unique case (state_q)
      S_IDLE: begin
        // A stray done here is consumed with no effect.
        if (frame_start_i) begin
          si_d    = 1'b1;
          start_d = 1'b1;
          chan_d  = CH_POT0;
          sideb_d = 1'b0;
          state_d = S_POT0;
        end
      end
      S_POT0: begin
        if (adc_done_i) begin
          pot0_d  = adc_data_i;
          start_d = 1'b1;
          chan_d  = CH_POT1;
          sideb_d = 1'b0;
          state_d = S_POT1;
        end
      end
      S_POT1: begin
        if (adc_done_i) begin
          pot1_d  = adc_data_i;
          start_d = 1'b1;
          chan_d  = CH_BATT;
          sideb_d = 1'b1;
          state_d = S_BATT;
        end
      end
      S_BATT: begin
        if (adc_done_i) begin
          batt_d     = adc_data_i;
          sclk_d     = 1'b1;
          tmr_load_o = 1'b1;
          state_d    = S_SETUP;
        end
      end
      S_SETUP: begin
        if (tmr_expire_i) begin
          si_d    = 1'b0;
          start_d = 1'b1;
          chan_d  = CH_CAM0;
          sideb_d = 1'b1;
          cam_d   = 1'b0;
          pix_d   = '0;
          state_d = S_LINE;
        end
      end
      S_LINE: begin
        if (adc_done_i) begin
          wr_en_o = 1'b1;
          if (!cam_q) begin
            start_d = 1'b1;
            chan_d  = CH_CAM1;
            cam_d   = 1'b1;
          end else begin
            pix_d      = pix_q + 1'b1;
            sclk_d     = 1'b0;
            tmr_load_o = 1'b1;
            state_d    = S_PULSE;
          end
        end
      end
      S_PULSE: begin
        if (tmr_expire_i) begin
          sclk_d = 1'b1;
          if (pix_q == PIX_END) begin
            tmr_load_o = 1'b1;
            state_d    = S_TAIL;
          end else begin
            start_d = 1'b1;
            chan_d  = CH_CAM0;
            cam_d   = 1'b0;
            state_d = S_LINE;
          end
        end
      end
      S_TAIL: begin
        if (tmr_expire_i) begin
          sclk_d  = 1'b0;
          swap_o  = 1'b1;
          cnt_d   = cnt_q + 1'b1;
          state_d = S_IDLE;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      si_q    <= 1'b0;
      sclk_q  <= 1'b0;
      start_q <= 1'b0;
      chan_q  <= '0;
      sideb_q <= 1'b0;
      cam_q   <= 1'b0;
      pix_q   <= '0;
      pot0_q  <= '0;
      pot1_q  <= '0;
      batt_q  <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      si_q    <= si_d;
      sclk_q  <= sclk_d;
      start_q <= start_d;
      chan_q  <= chan_d;
      sideb_q <= sideb_d;
      cam_q   <= cam_d;
      pix_q   <= pix_d;
      pot0_q  <= pot0_d;
      pot1_q  <= pot1_d;
      batt_q  <= batt_d;
      cnt_q   <= cnt_d;
    end
  end

  assign adc_start_o  = start_q;
  assign adc_chan_o   = chan_q;
  assign adc_side_b_o = sideb_q;
  assign sensor_si_o  = si_q;
  assign sensor_clk_o = sclk_q;
  assign pot0_o       = pot0_q;
  assign pot1_o       = pot1_q;
  assign batt_o       = batt_q;
  assign ready_cnt_o  = cnt_q;
  assign wr_cam_o     = cam_q;
  assign wr_addr_o    = pix_q[ADDR_W-1:0];
  assign wr_data_o    = adc_data_i;

  // R2: the line-start pin rises together with the pot-0 request
  a_r2_si_rise_pot0: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(si_q) |-> (start_q && chan_q == CH_POT0 && !sideb_q));

  // R3: every request is a single-cycle pulse
  a_r3_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);

  // R3: mux side B only for battery and camera channels
  a_r3_side_matches: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> (sideb_q == (chan_q == CH_BATT || chan_q == CH_CAM0 || chan_q == CH_CAM1)));

  // R4: line-start fall releases the first pixel request with the clock high
  a_r4_si_fall_first_pix: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(si_q) |-> (start_q && chan_q == CH_CAM0 && sclk_q));

  // R5: no request while the sensor clock is low in the pixel phase
  a_r5_quiet_when_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_q && !si_q) |-> !start_q);

  // R6: the bank swap lands with the final clock fall and one count step
  a_r6_swap_with_fall: assert property (@(posedge clk) disable iff (!rst_n)
    swap_o |=> ($fell(sclk_q) && cnt_q == $past(cnt_q) + 1'b1));

  // R10: a frame only begins out of idle
  a_r10_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(si_q) |-> ($past(state_q) == S_IDLE));

endmodule

// File: rtl/lsc_adc_sequencer.sv
module lsc_adc_sequencer
  import lsc_pkg::*;
#(
  parameter int PIXELS   = 128,
  parameter int DATA_W   = 12,
  parameter int CNT_W    = 8,
  parameter int HOLD_CYC = 50,
  localparam int ADDR_W  = $clog2(PIXELS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start_i,
  output logic              adc_start_o,
  output logic [CH_W-1:0]   adc_chan_o,
  output logic              adc_side_b_o,
  input  logic              adc_done_i,
  input  logic [DATA_W-1:0] adc_data_i,
  output logic              sensor_si_o,
  output logic              sensor_clk_o,
  output logic [DATA_W-1:0] pot0_o,
  output logic [DATA_W-1:0] pot1_o,
  output logic [DATA_W-1:0] batt_o,
  output logic [CNT_W-1:0]  ready_cnt_o,
  output logic              rd_bank_o,
  input  logic              rd_cam_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);

  logic              tmr_load;
  logic              tmr_expire;
  logic              wr_en;
  logic              wr_cam;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              swap;

  lsc_seq_fsm #(
    .PIXELS (PIXELS),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_start_i (frame_start_i),
    .adc_done_i    (adc_done_i),
    .adc_data_i    (adc_data_i),
    .tmr_expire_i  (tmr_expire),
    .tmr_load_o    (tmr_load),
    .adc_start_o   (adc_start_o),
    .adc_chan_o    (adc_chan_o),
    .adc_side_b_o  (adc_side_b_o),
    .sensor_si_o   (sensor_si_o),
    .sensor_clk_o  (sensor_clk_o),
    .pot0_o        (pot0_o),
    .pot1_o        (pot1_o),
    .batt_o        (batt_o),
    .ready_cnt_o   (ready_cnt_o),
    .wr_en_o       (wr_en),
    .wr_cam_o      (wr_cam),
    .wr_addr_o     (wr_addr),
    .wr_data_o     (wr_data),
    .swap_o        (swap)
  );

  lsc_hold_timer #(
    .HOLD_CYC (HOLD_CYC)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (tmr_load),
    .expire_o (tmr_expire)
  );

  lsc_frame_buffer #(
    .PIXELS (PIXELS),
    .DATA_W (DATA_W)
  ) u_fbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en),
    .wr_cam_i  (wr_cam),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .swap_i    (swap),
    .rd_cam_i  (rd_cam_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .rd_bank_o (rd_bank_o)
  );

endmodule

// File: tb/lsc_adc_sequencer_tb.sv
module lsc_adc_sequencer_tb;

  localparam int PIX    = 128;
  localparam int HOLD   = 50;
  localparam int LAT    = 3;
  localparam int AW     = 7;
  localparam int NCONV  = 3 + 2 * PIX;

  logic        clk;
  logic        rst_n;
  logic        frame_start;
  logic        adc_start;
  logic [4:0]  adc_chan;
  logic        adc_side_b;
  logic        adc_done;
  logic [11:0] adc_data;
  logic        si, sclk;
  logic [11:0] pot0, pot1, batt;
  logic [7:0]  ready;
  logic        rd_bank;
  logic        rd_cam;
  logic [AW-1:0] rd_addr;
  logic [11:0] rd_data;

  int n_chk;
  int n_fail;

  lsc_adc_sequencer u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_start_i (frame_start),
    .adc_start_o   (adc_start),
    .adc_chan_o    (adc_chan),
    .adc_side_b_o  (adc_side_b),
    .adc_done_i    (adc_done),
    .adc_data_i    (adc_data),
    .sensor_si_o   (si),
    .sensor_clk_o  (sclk),
    .pot0_o        (pot0),
    .pot1_o        (pot1),
    .batt_o        (batt),
    .ready_cnt_o   (ready),
    .rd_bank_o     (rd_bank),
    .rd_cam_i      (rd_cam),
    .rd_addr_i     (rd_addr),
    .rd_data_o     (rd_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [11:0] pix_val(input logic [11:0] s, input int cam, input int k);
    return 12'(int'(s) + k * 5 + cam * 2048);
  endfunction

  // ---------------- converter model ----------------
  logic [11:0] seed, pot0_v, pot1_v, batt_v;
  logic        mdl_done, pend, inj_done;
  logic [11:0] mdl_data, inj_data;
  int          lat_cnt, seq_idx, starts_total, seq_err, pos_err;

  assign adc_done = mdl_done | inj_done;
  assign adc_data = inj_done ? inj_data : mdl_data;

  always @(posedge clk) begin
    if (!rst_n) begin
      mdl_done <= 1'b0;
      pend     <= 1'b0;
      mdl_data <= '0;
    end else begin
      mdl_done <= 1'b0;
      if (pend) begin
        if (lat_cnt == 0) begin
          mdl_done <= 1'b1;
          pend     <= 1'b0;
        end else begin
          lat_cnt <= lat_cnt - 1;
        end
      end
      if (adc_start) begin
        automatic int exp_ch;
        automatic logic exp_side;
        if (adc_chan == 5'd13) seq_idx = 0;
        if (pend) pos_err++;
        case (seq_idx)
          0: begin exp_ch = 13; exp_side = 1'b0; mdl_data <= pot0_v; end
          1: begin exp_ch = 12; exp_side = 1'b0; mdl_data <= pot1_v; end
          2: begin exp_ch = 4;  exp_side = 1'b1; mdl_data <= batt_v; end
          default: begin
            exp_ch   = ((seq_idx - 3) % 2 == 0) ? 6 : 7;
            exp_side = 1'b1;
            mdl_data <= pix_val(seed, (seq_idx - 3) % 2, (seq_idx - 3) / 2);
          end
        endcase
        if (int'(adc_chan) != exp_ch || adc_side_b != exp_side) seq_err++;
        if (adc_chan == 5'd6 && !(sclk && !si)) pos_err++;
        pend    <= 1'b1;
        lat_cnt <= LAT - 1;
        starts_total++;
        seq_idx++;
      end
    end
  end

  // ---------------- sensor pin monitor ----------------
  int   cyc, rises, low_run, low_min, low_max;
  int   first_rise_cyc, si_fall_cyc, last_rise_cyc, fall_cyc;
  logic clk_prev, si_prev;

  always @(negedge clk) begin
    cyc++;
    if (si && !si_prev) begin
      rises   = 0;
      low_run = 0;
      low_min = 1 << 30;
      low_max = 0;
    end
    if (sclk && !clk_prev) begin
      rises++;
      if (rises > 1) begin
        if (low_run < low_min) low_min = low_run;
        if (low_run > low_max) low_max = low_run;
      end else begin
        first_rise_cyc = cyc;
      end
      last_rise_cyc = cyc;
      low_run = 0;
    end else if (!sclk) begin
      low_run++;
    end
    if (!sclk && clk_prev) fall_cyc = cyc;
    if (!si && si_prev) si_fall_cyc = cyc;
    clk_prev = sclk;
    si_prev  = si;
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic strobe();
    @(negedge clk) frame_start = 1'b1;
    @(negedge clk) frame_start = 1'b0;
  endtask

  task automatic read_frame(input logic [11:0] s, output int errs);
    errs = 0;
    for (int c = 0; c < 2; c++) begin
      for (int k = 0; k < PIX; k++) begin
        @(negedge clk);
        rd_cam  = c[0];
        rd_addr = AW'(k);
        @(negedge clk);
        if (rd_data != pix_val(s, c, k)) errs++;
      end
    end
  endtask

  task automatic wait_frame(input logic [7:0] from);
    while (ready == from) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    @(negedge clk);
    chk(si == 1'b0 && sclk == 1'b0, "R1", "pins after reset", {si, sclk}, 0);
    chk(adc_start == 1'b0, "R1", "start after reset", adc_start, 0);
    chk(ready == 8'd0, "R1", "frame counter after reset", ready, 0);
    chk(rd_bank == 1'b1, "R1", "readable bank after reset", rd_bank, 1);
  endtask

  task automatic t_first_frame();
    int base, errs;
    logic [7:0] c0;
    logic b0;
    seed = 12'h123; pot0_v = 12'h0A5; pot1_v = 12'hFFF; batt_v = 12'h7C0;
    base = starts_total; c0 = ready; b0 = rd_bank;
    @(negedge clk) frame_start = 1'b1;
    @(negedge clk) frame_start = 1'b0;
    chk(si && adc_start && adc_chan == 5'd13 && !adc_side_b, "R2",
        "start pin and pot0 request after strobe", {si, adc_start, adc_chan, adc_side_b}, {1'b1, 1'b1, 5'd13, 1'b0});
    wait_frame(c0);
    chk(seq_err == 0, "R3", "channel order errors", seq_err, 0);
    chk(starts_total - base == NCONV, "R3", "requests per frame", starts_total - base, NCONV);
    chk(pot0 == 12'h0A5 && pot1 == 12'hFFF && batt == 12'h7C0, "R3",
        "held results", {pot0, pot1, batt}, {12'h0A5, 12'hFFF, 12'h7C0});
    chk(si_fall_cyc - first_rise_cyc == HOLD, "R4", "clock high before start-pin fall",
        si_fall_cyc - first_rise_cyc, HOLD);
    chk(pos_err == 0, "R4", "pixel requests with bad pin state or overlap", pos_err, 0);
    chk(low_min == HOLD && low_max == HOLD, "R5", "low pulse width min/max",
        low_min * 1000 + low_max, HOLD * 1000 + HOLD);
    chk(rises == PIX + 1, "R6", "clock rising edges", rises, PIX + 1);
    chk(fall_cyc - last_rise_cyc == HOLD, "R6", "final high hold", fall_cyc - last_rise_cyc, HOLD);
    chk(ready == c0 + 8'd1 && rd_bank == ~b0, "R6", "counter and bank after frame",
        {ready, rd_bank}, {c0 + 8'd1, ~b0});
    read_frame(12'h123, errs);
    chk(errs == 0, "R7", "pixel mismatches in readable bank", errs, 0);
  endtask

  task automatic t_idle_done();
    int base;
    logic [11:0] p0;
    logic [7:0] c0;
    base = starts_total; p0 = pot0; c0 = ready;
    @(negedge clk);
    inj_data = 12'hABC;
    inj_done = 1'b1;
    @(negedge clk) inj_done = 1'b0;
    repeat (20) @(negedge clk);
    chk(starts_total == base && !si, "R9", "requests after idle done", starts_total - base, 0);
    chk(pot0 == p0 && ready == c0, "R9", "held state after idle done", {pot0, ready}, {p0, c0});
  endtask

  task automatic t_busy_frame();
    int base, errs;
    logic [7:0] c0;
    seed = 12'h9E1; pot0_v = 12'h000; pot1_v = 12'h321; batt_v = 12'h555;
    base = starts_total; c0 = ready;
    strobe();
    repeat (2000) @(negedge clk);
    strobe();
    read_frame(12'h123, errs);
    chk(errs == 0, "R8", "readable bank changed during capture", errs, 0);
    chk(ready == c0, "R8", "frame still running during readback", ready, c0);
    wait_frame(c0);
    chk(ready == c0 + 8'd1, "R10", "frames completed", ready - c0, 1);
    chk(starts_total - base == NCONV && seq_err == 0, "R10", "requests with stray strobe",
        starts_total - base, NCONV);
    base = starts_total;
    repeat (300) @(negedge clk);
    chk(starts_total == base && !si, "R10", "requests after frame end", starts_total - base, 0);
    read_frame(12'h9E1, errs);
    chk(errs == 0, "R7", "second frame pixel mismatches", errs, 0);
    chk(pot0 == 12'h000 && batt == 12'h555, "R3", "results of second frame",
        {pot0, batt}, {12'h000, 12'h555});
  endtask

  // ---------------- main ----------------
  bit done_flag;

  initial begin
    n_chk = 0; n_fail = 0; done_flag = 1'b0;
    seq_idx = 0; starts_total = 0; seq_err = 0; pos_err = 0; lat_cnt = 0;
    cyc = 0; rises = 0; low_run = 0; low_min = 0; low_max = 0;
    first_rise_cyc = 0; si_fall_cyc = 0; last_rise_cyc = 0; fall_cyc = 0;
    clk_prev = 1'b0; si_prev = 1'b0;
    frame_start = 1'b0; inj_done = 1'b0; inj_data = '0;
    rd_cam = 1'b0; rd_addr = '0;
    seed = '0; pot0_v = '0; pot1_v = '0; batt_v = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_first_frame();
    t_idle_done();
    t_busy_frame();
    done_flag = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule